// File: doc/BRIEF.md
# Maskable Dual Time-of-Day Alarm

This block holds two independent time-of-day alarms. Each alarm stores four match bytes: second, minute, hour and weekday, in the same BCD encoding the timekeeper uses. A one-cycle `time_tick` strobe marks each timekeeper update. On that strobe, each alarm compares its bytes with the current time. If every unmasked field agrees, the alarm raises its request flag. Bit 7 of each stored byte is a "don't care" mask, and setting it drops that field from the comparison. This gives weekly, daily, hourly, per-minute and per-second alarms.

The host reaches the match bytes through an 8-bit address. Address bit 7 selects a write and bits 6:0 select the register. Alarm 0 sits at index 07h–0Ah and alarm 1 at index 0Bh–0Eh. Within each range the field order is second, minute, hour, weekday. Any access (read or write) whose index falls inside an alarm's range clears that alarm's flag.

Alarm 0 drives an active-low level interrupt that stays asserted while its flag and its enable are both set. Alarm 1 drives an active-high pulse. The pulse has a fixed length, counted in strobes of a slow reference clock (2048 strobes of a 32.768 kHz clock give 62.5 ms).

Top module: `tod_alarm_pair`

## Requirements
- R1: After reset, both flags are 0, `irq0_n` is 1, `irq1` is 0, and every alarm byte reads 00h.
- R2: A write to address 87h+k (k = 0..3) stores `acc_wdata` in alarm 0 field k, and a write to 8Bh+k stores it in alarm 1 field k. Fields are ordered second, minute, hour, weekday. Reading index 07h+k or 0Bh+k returns the stored byte on `acc_rdata` in the same cycle. An access with address bit 7 clear writes nothing. Every other index reads 00h.
- R3: In a cycle with `time_tick` high and all four mask bits 0, an alarm's flag is set at the next edge only if bits 6:0 of all four stored bytes equal the current second, minute, hour and weekday. Without `time_tick`, no flag is set.
- R4: A byte with bit 7 set is excluded from its alarm's comparison. Masking the weekday gives a daily match. Also masking the hour gives an hourly match. With all four masked, the alarm matches on every tick.
- R5: The hour comparison covers bits 6:0, including the 12-hour select bit 6 and the PM bit 5. A difference in either bit prevents a match.
- R6: `irq0_n` is 0 exactly while alarm 0's flag is 1 and `int0_en` is 1.
- R7: When alarm 1 matches on a tick while `int1_en` is 1, `irq1` goes high after that edge and stays high for PULSE_TICKS `slow_strobe` cycles. While `int1_en` is 0, `irq1` is 0, but the flag still sets.
- R8: An access to any index of one alarm's range clears that alarm's flag at the next edge. Accesses outside that range leave it unchanged.
- R9: If a tick sets a flag in the same cycle as an access that would clear it, the flag ends up 1.
- R10: A new alarm 1 match during a pulse restarts the full pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_tick | input | 1 | One-cycle strobe marking a timekeeper update |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour byte (format bit 6, PM/20h bit 5) |
| now_dow | input | 8 | Current weekday |
| slow_strobe | input | 1 | Enable strobe of the pulse reference clock |
| acc_valid | input | 1 | Host access in this cycle |
| acc_addr | input | 8 | Bit 7 = write, bits 6:0 = register index |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the indexed register |
| int0_en | input | 1 | Enable of the alarm 0 interrupt |
| int1_en | input | 1 | Enable of the alarm 1 pulse |
| flag0 | output | 1 | Alarm 0 request flag |
| flag1 | output | 1 | Alarm 1 request flag |
| irq0_n | output | 1 | Alarm 0 interrupt, active low, level |
| irq1 | output | 1 | Alarm 1 interrupt, active-high pulse |

## Verification
Some properties are checked on every cycle by assertions. A flag may only rise after a tick. A touch without a coinciding match always clears the flag. A match takes priority over a clear. An all-masked alarm always fires on a tick. A running pulse always holds a nonzero count. The bench scenarios cover what the assertions cannot judge: the address map and field order, whether a specific mask pattern or hour format bit gives the right match, the exact pulse length, the restart on a new match, and that accesses to the neighbouring alarm leave a flag alone.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
   localparam int BYTE_W  = 8;
   localparam int FIELD_N = 4;
   localparam int UNIT_N  = 2;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef byte_t [FIELD_N-1:0] tod_t;

   // field order inside an alarm's address range; hardware decodes it
   typedef enum logic [1:0] {
      FLD_SEC  = 2'd0,
      FLD_MIN  = 2'd1,
      FLD_HOUR = 2'd2,
      FLD_DOW  = 2'd3
   } field_e;
endpackage

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit #(
   parameter int FIELDS = 4,
   parameter int DW     = 8,
   parameter int SEL_W  = (FIELDS > 1) ? $clog2(FIELDS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic [FIELDS-1:0][DW-1:0]    now_i,
   input  logic                         touch,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             sel,
   input  logic [DW-1:0]                wdata,
   output logic [FIELDS-1:0][DW-1:0]    regs_o,
   output logic                         match_o,
   output logic                         flag_o
);
   localparam int MASK_BIT = DW - 1;

   if (DW < 2) begin : g_bad_dw
      $error("tod_alarm_unit: DW must be at least 2");
   end
   if (FIELDS < 1) begin : g_bad_fields
      $error("tod_alarm_unit: FIELDS must be at least 1");
   end

   logic [FIELDS-1:0][DW-1:0] regs_q;
   logic [FIELDS-1:0]         field_ok;
   logic [FIELDS-1:0]         masked;
   logic                      flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (wr_en && (int'(sel) < FIELDS)) begin
         regs_q[sel] <= wdata;
      end
   end

   for (genvar f = 0; f < FIELDS; f++) begin : g_cmp
      assign masked[f]   = regs_q[f][MASK_BIT];
      assign field_ok[f] = masked[f] ||
                           (regs_q[f][MASK_BIT-1:0] == now_i[f][MASK_BIT-1:0]);
   end

   assign match_o = &field_ok;

   // a fresh match wins over a clearing touch in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (tick && match_o) begin
         flag_q <= 1'b1;
      end else if (touch) begin
         flag_q <= 1'b0;
      end
   end

   assign regs_o = regs_q;
   assign flag_o = flag_q;

   assert_flag_rise_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick));

   assert_touch_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (touch && !tick) |=> !flag_q);

   assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && match_o && touch) |=> flag_q);

   assert_all_masked_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (&masked)) |=> flag_q);
endmodule

// File: rtl/tod_pulse_timer.sv
module tod_pulse_timer #(
   parameter int LEN = 2048,
   parameter int CW  = $clog2(LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic strobe,
   input  logic enable,
   output logic pulse_o
);
   if (LEN < 1) begin : g_bad_len
      $error("tod_pulse_timer: LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= CW'(LEN);
      end else if (active_q && strobe) begin
         if (cnt_q == CW'(1)) begin
            active_q <= 1'b0;
         end
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign pulse_o = active_q && enable;

   assert_active_has_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q != '0));

   assert_restart_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (active_q && $past(strobe) |-> 1'b1) && active_q);
endmodule

// File: rtl/tod_alarm_pair.sv
module tod_alarm_pair
   import tod_alarm_pkg::*;
#(
   parameter int AW          = 8,
   parameter int ALARM0_BASE = 7,
   parameter int PULSE_TICKS = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              time_tick,
   input  logic [BYTE_W-1:0] now_sec,
   input  logic [BYTE_W-1:0] now_min,
   input  logic [BYTE_W-1:0] now_hour,
   input  logic [BYTE_W-1:0] now_dow,
   input  logic              slow_strobe,
   input  logic              acc_valid,
   input  logic [AW-1:0]     acc_addr,
   input  logic [BYTE_W-1:0] acc_wdata,
   output logic [BYTE_W-1:0] acc_rdata,
   input  logic              int0_en,
   input  logic              int1_en,
   output logic              flag0,
   output logic              flag1,
   output logic              irq0_n,
   output logic              irq1
);
   localparam int IDX_W = AW - 1;
   localparam int SEL_W = $clog2(FIELD_N);

   if (AW < 5) begin : g_bad_aw
      $error("tod_alarm_pair: AW too small for the alarm map");
   end
   if (ALARM0_BASE + UNIT_N * FIELD_N >= (1 << (AW - 1))) begin : g_bad_base
      $error("tod_alarm_pair: alarm ranges exceed the index space");
   end

   logic [IDX_W-1:0] idx;
   logic             is_wr;
   tod_t             now_vec;
   tod_t             regs  [UNIT_N];
   logic [UNIT_N-1:0] touch;
   logic [UNIT_N-1:0] match;
   logic [UNIT_N-1:0] flag;
   logic [SEL_W-1:0]  sel   [UNIT_N];

   assign idx   = acc_addr[IDX_W-1:0];
   assign is_wr = acc_addr[AW-1];

   always_comb begin
      now_vec          = '0;
      now_vec[FLD_SEC]  = now_sec;
      now_vec[FLD_MIN]  = now_min;
      now_vec[FLD_HOUR] = now_hour;
      now_vec[FLD_DOW]  = now_dow;
   end

   for (genvar u = 0; u < UNIT_N; u++) begin : g_unit
      localparam int BASE = ALARM0_BASE + u * FIELD_N;

      assign touch[u] = acc_valid &&
                        (idx >= IDX_W'(BASE)) &&
                        (idx <  IDX_W'(BASE + FIELD_N));
      assign sel[u]   = SEL_W'(idx - IDX_W'(BASE));

      tod_alarm_unit #(
         .FIELDS (FIELD_N),
         .DW     (BYTE_W),
         .SEL_W  (SEL_W)
      ) unit_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (time_tick),
         .now_i   (now_vec),
         .touch   (touch[u]),
         .wr_en   (touch[u] && is_wr),
         .sel     (sel[u]),
         .wdata   (acc_wdata),
         .regs_o  (regs[u]),
         .match_o (match[u]),
         .flag_o  (flag[u])
      );
   end

   always_comb begin
      acc_rdata = '0;
      for (int u = 0; u < UNIT_N; u++) begin
         for (int f = 0; f < FIELD_N; f++) begin
            if (idx == IDX_W'(ALARM0_BASE + u * FIELD_N + f)) begin
               acc_rdata = regs[u][f];
            end
         end
      end
   end

   assign flag0  = flag[0];
   assign flag1  = flag[1];
   assign irq0_n = !(flag[0] && int0_en);

   tod_pulse_timer #(
      .LEN (PULSE_TICKS)
   ) pulse_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (time_tick && match[1] && int1_en),
      .strobe  (slow_strobe),
      .enable  (int1_en),
      .pulse_o (irq1)
   );

   assert_irq0_asserts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag[0]) && int0_en) |-> !irq0_n);

   assert_irq0_drops_on_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[0]) |-> irq0_n);

   assert_one_alarm_touched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(touch));
endmodule

// File: tb/tod_alarm_pair_tb_top.sv
module tod_alarm_pair_tb_top;
   localparam int PT = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       time_tick = 1'b0;
   logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_dow = '0;
   logic       slow_strobe = 1'b1;
   logic       acc_valid = 1'b0;
   logic [7:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       int0_en = 1'b0, int1_en = 1'b0;
   logic       flag0, flag1, irq0_n, irq1;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tod_alarm_pair #(.PULSE_TICKS(PT)) dut_i (
      .clk(clk), .rst_n(rst_n), .time_tick(time_tick),
      .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_dow(now_dow),
      .slow_strobe(slow_strobe), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .int0_en(int0_en),
      .int1_en(int1_en), .flag0(flag0), .flag1(flag1), .irq0_n(irq0_n), .irq1(irq1)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      acc_valid = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      acc_valid = 1'b1; acc_addr = a; acc_wdata = 8'hFF;
      #1 d = acc_rdata;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic touch(input logic [7:0] a);
      logic [7:0] d;
      rd(a, d);
   endtask

   task automatic set_now(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] w);
      now_sec = s; now_min = m; now_hour = h; now_dow = w;
   endtask

   task automatic do_tick(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] w);
      set_now(s, m, h, w);
      time_tick = 1'b1;
      @(negedge clk);
      time_tick = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 flag0", flag0, 0);
      check("R1 flag1", flag1, 0);
      check("R1 irq0_n", irq0_n, 1);
      check("R1 irq1", irq1, 0);
      rd(8'h07, d); check("R1 alarm0 sec", d, 0);
      rd(8'h0E, d); check("R1 alarm1 dow", d, 0);
   endtask

   task automatic t_regs;
      logic [7:0] d;
      wr(8'h87, 8'h30); wr(8'h88, 8'h15); wr(8'h89, 8'h08); wr(8'h8A, 8'h03);
      wr(8'h8B, 8'h45); wr(8'h8C, 8'h59); wr(8'h8D, 8'h23); wr(8'h8E, 8'h07);
      rd(8'h07, d); check("R2 a0 sec", d, 8'h30);
      rd(8'h09, d); check("R2 a0 hour", d, 8'h08);
      rd(8'h0A, d); check("R2 a0 dow", d, 8'h03);
      rd(8'h0B, d); check("R2 a1 sec", d, 8'h45);
      rd(8'h0C, d); check("R2 a1 min", d, 8'h59);
      rd(8'h0E, d); check("R2 a1 dow", d, 8'h07);
      rd(8'h08, d); rd(8'h08, d); check("R2 read does not write", d, 8'h15);
      wr(8'h8F, 8'h55); rd(8'h0F, d); check("R2 outside reads 0", d, 0);
      rd(8'h06, d); check("R2 below range reads 0", d, 0);
   endtask

   task automatic t_exact;
      set_now(8'h30, 8'h15, 8'h08, 8'h03);
      repeat (2) @(negedge clk);
      check("R3 no tick no flag", flag0, 0);
      do_tick(8'h30, 8'h16, 8'h08, 8'h03);
      check("R3 minute mismatch", flag0, 0);
      do_tick(8'h30, 8'h15, 8'h08, 8'h04);
      check("R3 weekday mismatch", flag0, 0);
      do_tick(8'h30, 8'h15, 8'h08, 8'h03);
      check("R3 exact match", flag0, 1);
      check("R3 other alarm quiet", flag1, 0);
      touch(8'h07);
   endtask

   task automatic t_masks;
      wr(8'h8A, 8'h83);
      do_tick(8'h30, 8'h15, 8'h08, 8'h05);
      check("R4 daily match", flag0, 1);
      touch(8'h07);
      do_tick(8'h31, 8'h15, 8'h08, 8'h05);
      check("R4 daily second differs", flag0, 0);
      wr(8'h89, 8'h88);
      do_tick(8'h30, 8'h15, 8'h11, 8'h02);
      check("R4 hourly match", flag0, 1);
      touch(8'h07);
      do_tick(8'h30, 8'h16, 8'h11, 8'h02);
      check("R4 hourly minute differs", flag0, 0);
      wr(8'h88, 8'h95); wr(8'h87, 8'hB0);
      do_tick(8'h00, 8'h00, 8'h00, 8'h00);
      check("R4 all masked fires", flag0, 1);
      touch(8'h07);
   endtask

   task automatic t_hourfmt;
      wr(8'h87, 8'h30); wr(8'h88, 8'h15); wr(8'h89, 8'h52); wr(8'h8A, 8'h03);
      touch(8'h07);
      do_tick(8'h30, 8'h15, 8'h72, 8'h03);
      check("R5 PM bit differs", flag0, 0);
      do_tick(8'h30, 8'h15, 8'h12, 8'h03);
      check("R5 format bit differs", flag0, 0);
      do_tick(8'h30, 8'h15, 8'h52, 8'h03);
      check("R5 12h hour matches", flag0, 1);
   endtask

   task automatic t_irq0;
      check("R6 disabled stays high", irq0_n, 1);
      int0_en = 1'b1;
      #1 check("R6 enabled asserts", irq0_n, 0);
      @(negedge clk);
      check("R6 held while flag set", irq0_n, 0);
      touch(8'h0A);
      check("R6 clears with flag", irq0_n, 1);
      int0_en = 1'b0;
   endtask

   task automatic t_clear;
      do_tick(8'h45, 8'h59, 8'h23, 8'h07);
      do_tick(8'h30, 8'h15, 8'h52, 8'h03);
      check("R8 setup flag1", flag1, 1);
      check("R8 setup flag0", flag0, 1);
      touch(8'h06); touch(8'h0F);
      check("R8 outside keeps flag0", flag0, 1);
      check("R8 outside keeps flag1", flag1, 1);
      wr(8'h8B, 8'h45);
      check("R8 write clears flag1", flag1, 0);
      check("R8 other alarm keeps flag0", flag0, 1);
      touch(8'h07);
      check("R8 read clears flag0", flag0, 0);
   endtask

   task automatic t_setwins;
      acc_valid = 1'b1; acc_addr = 8'h08;
      do_tick(8'h30, 8'h15, 8'h52, 8'h03);
      acc_valid = 1'b0;
      check("R9 set beats clear", flag0, 1);
      touch(8'h07);
   endtask

   task automatic count_high(output int n);
      n = 0;
      while (irq1 && n < 3 * PT) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_pulse;
      int n;
      wr(8'h8B, 8'h80); wr(8'h8C, 8'h80); wr(8'h8D, 8'h80); wr(8'h8E, 8'h80);
      int1_en = 1'b0;
      do_tick(8'h01, 8'h02, 8'h03, 8'h04);
      check("R7 disabled flag sets", flag1, 1);
      n = 0;
      repeat (40) begin
         if (irq1) n++;
         @(negedge clk);
      end
      check("R7 disabled stays low", n, 0);
      int1_en = 1'b1;
      do_tick(8'h01, 8'h02, 8'h03, 8'h04);
      count_high(n);
      check("R7 pulse length", n, PT);
   endtask

   task automatic t_retrig;
      int n;
      do_tick(8'h05, 8'h02, 8'h03, 8'h04);
      repeat (100) @(negedge clk);
      check("R10 still high", irq1, 1);
      do_tick(8'h06, 8'h02, 8'h03, 8'h04);
      count_high(n);
      check("R10 restarted length", n, PT);
      int1_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_exact();
      t_masks();
      t_hourfmt();
      t_irq0();
      t_clear();
      t_setwins();
      t_pulse();
      t_retrig();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule